// File: doc/BRIEF.md
# Edge-Sensitive Interrupt Status Collector

This block gathers a fixed set of alarm and event lines into sticky pending bits and one active-high interrupt request. Each source is declared at elaboration as either a level source or an event source. A level source has a status bit that follows its condition, and the pending bit for that source is set by any change of the status bit, whether rising or falling. An event source has no status bit, and a pulse on it sets its pending bit directly.

Software clears pending bits with a write strobe and a per-bit mask. Only the bits set in the mask are cleared. If a new set and a clear for the same bit arrive in the same cycle, the set wins, so no event is lost. A per-source enable vector gates which pending bits can raise the interrupt request. Each source input passes through one register before its edge is detected. Every set therefore becomes visible a fixed two clock edges after the input changes.

Top module: `irq_collector`

## Requirements
- R1: After reset, all bits of `pendOut` and `statusOut` are 0 and `irqOut` is 0.
- R2: Bit i of parameter `LEVEL_MAP` set to 1 makes source i a level source, and 0 makes it an event source. For a level source, `statusOut[i]` equals `srcIn[i]` one clock edge earlier. For an event source, `statusOut[i]` is always 0.
- R3: A 0-to-1 change of a level source sets `pendOut[i]` at the second rising clock edge after the input change, and not at the first.
- R4: A 1-to-0 change of a level source also sets `pendOut[i]`, with the same two-edge latency.
- R5: Event source i sets `pendOut[i]` at the second rising edge after `srcIn[i]` is high, even for a single-cycle pulse.
- R6: A pending bit stays at 1 after its source goes quiet or returns to its earlier value, until it is cleared.
- R7: At a rising edge with `clrStrobe` high, every pending bit whose `clrMask` bit is 1 is cleared and all other bits are unchanged. With `clrStrobe` low, `clrMask` has no effect.
- R8: When a set and a clear hit the same pending bit at the same edge, the bit stays at 1.
- R9: `irqOut` is 1 exactly when some bit is 1 in both `pendOut` and `enableMask`. It follows the enable vector with no clock delay. A disabled pending bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Source condition (level) or pulse (event) lines |
| clrStrobe | input | 1 | Host clear write strobe |
| clrMask | input | NUM_SRC | Write-one-to-clear data for pending bits |
| enableMask | input | NUM_SRC | Per-source interrupt enable |
| statusOut | output | NUM_SRC | Registered status for level sources, 0 for event sources |
| pendOut | output | NUM_SRC | Sticky pending bits |
| irqOut | output | 1 | Combined active-high interrupt request |

## Verification
The results have fixed timing:
- A status bit changes one rising edge after its source input changes.
- A pending bit is set two rising edges after the input changes, for both level and event sources.
- A clear takes effect at the edge where the strobe is sampled.
- The interrupt output responds to the enable vector within the same cycle.

The bench drives every input on the falling edge and reads outputs at the following falling edges. It checks both the intermediate cycle, where the status has moved but the pending bit has not, and the cycle where the pending bit is due. The set-versus-clear collision is built by placing the clear strobe in exactly the cycle where an event pulse sits in the input register.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes passed from the control module to the datapath each cycle
  typedef struct packed {
    logic clrValid;   // a host clear is being applied at this edge
  } irqCtrlT;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter bit IS_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srcIn,
  input  logic clrHit,
  output logic statusBit,
  output logic pendBit
);

  logic syncQ;
  logic setHit;

  // single input register ahead of edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 1'b0;
    else        syncQ <= srcIn;
  end

  generate
    if (IS_LEVEL) begin : g_level
      logic prevQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prevQ <= 1'b0;
        else        prevQ <= syncQ;
      end
      assign setHit    = syncQ ^ prevQ;
      assign statusBit = syncQ;

      // R3 R4
      level_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (statusBit != prevQ) |=> pendBit);
    end else begin : g_event
      assign setHit    = syncQ;
      assign statusBit = 1'b0;

      // R5
      event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syncQ |=> pendBit);
    end
  endgenerate

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendBit <= 1'b0;
    else        pendBit <= setHit | (pendBit & ~clrHit);
  end

  // R6
  sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendBit && !clrHit) |=> pendBit);

  // R7
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrHit && !setHit) |=> !pendBit);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrHit && setHit) |=> pendBit);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_SRC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clrStrobe,
  input  logic [NUM_SRC-1:0]  pendIn,
  input  logic [NUM_SRC-1:0]  enableMask,
  output irq_pkg::irqCtrlT    ctrlStrobe,
  output logic                irqOut
);

  assign ctrlStrobe.clrValid = clrStrobe;
  assign irqOut = |(pendIn & enableMask);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendIn & enableMask) == '0) |-> !irqOut);

  // R9
  irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendIn & enableMask) != '0) |-> irqOut);

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath #(
  parameter int                  NUM_SRC   = 8,
  parameter logic [NUM_SRC-1:0]  LEVEL_MAP = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic [NUM_SRC-1:0]  clrMask,
  input  irq_pkg::irqCtrlT    ctrlStrobe,
  output logic [NUM_SRC-1:0]  statusOut,
  output logic [NUM_SRC-1:0]  pendOut
);

  logic [NUM_SRC-1:0] clrVec;

  assign clrVec = ctrlStrobe.clrValid ? clrMask : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_cell #(.IS_LEVEL(LEVEL_MAP[i])) i_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .srcIn     (srcIn[i]),
      .clrHit    (clrVec[i]),
      .statusBit (statusOut[i]),
      .pendBit   (pendOut[i])
    );
  end

endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int                  NUM_SRC   = 8,
  parameter logic [NUM_SRC-1:0]  LEVEL_MAP = 8'h0F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic                clrStrobe,
  input  logic [NUM_SRC-1:0]  clrMask,
  input  logic [NUM_SRC-1:0]  enableMask,
  output logic [NUM_SRC-1:0]  statusOut,
  output logic [NUM_SRC-1:0]  pendOut,
  output logic                irqOut
);

  irq_pkg::irqCtrlT ctrlStrobe;

  irq_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clrStrobe  (clrStrobe),
    .pendIn     (pendOut),
    .enableMask (enableMask),
    .ctrlStrobe (ctrlStrobe),
    .irqOut     (irqOut)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .LEVEL_MAP(LEVEL_MAP)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcIn      (srcIn),
    .clrMask    (clrMask),
    .ctrlStrobe (ctrlStrobe),
    .statusOut  (statusOut),
    .pendOut    (pendOut)
  );

endmodule

// File: tb/test_irq_collector.sv
`timescale 1ns/1ps
module test_irq_collector;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] srcIn = '0;
  logic         clrStrobe = 1'b0;
  logic [N-1:0] clrMask = '0;
  logic [N-1:0] enableMask = '0;
  logic [N-1:0] statusOut;
  logic [N-1:0] pendOut;
  logic         irqOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // bits 3..0 level sources, bits 7..4 event sources
  irq_collector #(.NUM_SRC(N), .LEVEL_MAP(8'h0F)) i_irq_collector (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .clrStrobe(clrStrobe),
    .clrMask(clrMask), .enableMask(enableMask), .statusOut(statusOut),
    .pendOut(pendOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doClear(input logic [N-1:0] m);
    clrMask = m; clrStrobe = 1'b1;
    tick();
    clrStrobe = 1'b0; clrMask = '0;
  endtask

  task automatic tReset();
    check("R1 pend", pendOut, 0);
    check("R1 status", statusOut, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic tLevelRise();
    enableMask = '1;
    srcIn[0] = 1'b1;
    tick();
    check("R2 status follows", statusOut, 8'h01);
    check("R3 not yet", pendOut, 8'h00);
    tick();
    check("R3 rise pend", pendOut, 8'h01);
    check("R9 irq on", irqOut, 1);
    doClear(8'h01);
    check("R7 cleared", pendOut, 8'h00);
    check("R9 irq off", irqOut, 0);
  endtask

  task automatic tLevelFall();
    srcIn[0] = 1'b0;
    tick();
    check("R2 status fall", statusOut, 8'h00);
    check("R4 not yet", pendOut, 8'h00);
    tick();
    check("R4 fall pend", pendOut, 8'h01);
    tick(); tick();
    check("R6 sticky level", pendOut, 8'h01);
    doClear(8'h01);
    check("R7 cleared fall", pendOut, 8'h00);
  endtask

  task automatic tEvent();
    srcIn[5] = 1'b1;
    tick();
    srcIn[5] = 1'b0;
    check("R2 event no status", statusOut, 8'h00);
    check("R5 not yet", pendOut, 8'h00);
    tick();
    check("R5 event pend", pendOut, 8'h20);
    tick(); tick(); tick();
    check("R6 sticky event", pendOut, 8'h20);
  endtask

  task automatic tPartialClear();
    srcIn[1] = 1'b1;
    tick(); tick();
    check("R3 second source", pendOut, 8'h22);
    clrMask = 8'h22; clrStrobe = 1'b0;
    tick();
    check("R7 mask without strobe", pendOut, 8'h22);
    doClear(8'h02);
    check("R7 partial clear", pendOut, 8'h20);
    check("R2 status held", statusOut, 8'h02);
    doClear(8'h20);
    check("R7 event clear", pendOut, 8'h00);
  endtask

  task automatic tSetWins();
    srcIn[6] = 1'b1;
    tick();
    srcIn[6] = 1'b0;
    tick();
    check("R5 bit6 set", pendOut, 8'h40);
    srcIn[6] = 1'b1;
    tick();
    srcIn[6] = 1'b0;
    clrMask = 8'h40; clrStrobe = 1'b1;
    tick();
    clrStrobe = 1'b0; clrMask = '0;
    check("R8 set beats clear", pendOut, 8'h40);
    doClear(8'h40);
    check("R8 later clear", pendOut, 8'h00);
  endtask

  task automatic tEnable();
    enableMask = 8'hEF;
    srcIn[4] = 1'b1;
    tick();
    srcIn[4] = 1'b0;
    tick();
    check("R9 pend while disabled", pendOut, 8'h10);
    check("R9 irq masked", irqOut, 0);
    enableMask = 8'hFF;
    #1;
    check("R9 irq follows enable", irqOut, 1);
    tick();
    doClear(8'h10);
    check("R9 irq after clear", irqOut, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    tReset();
    rst_n = 1'b1;
    tick();
    tReset();
    tLevelRise();
    tLevelFall();
    tEvent();
    tPartialClear();
    tSetWins();
    tEnable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule